// File: doc/BRIEF.md
# Block Transfer Address Generator

This block is the requesting side of a wide data bus that serves a single memory target. A command carries a direction, a starting byte address, an 11-bit length code and a row stride. When the generator is idle it accepts the command and raises a bus request. Once the grant arrives it presents one word address at a time, with a byte-valid mask. It steps to the next word on each cycle in which the target signals a response. After the final word it signals completion.

The top bit of the length code selects between two ways of walking memory. In linear mode the lower ten bits give a byte count. The generator covers every word that touches the byte range, and it trims the masks of the first and last words to the exact bytes. In block mode the code holds a width in words and a height in rows. The generator sweeps each row word by word and then jumps to the next row start by the stride. A two-dimensional region, such as a tile of an image, is therefore fetched or stored with a single command.

Top module: `blk_xfer_agen`

## Requirements
- R1: While reset is held and right after it, bus_req and xfer_done are low and cmd_ready is high.
- R2: A command is taken only on a cycle with cmd_valid and cmd_ready both high, and cmd_ready is high exactly when the generator is idle. bus_req rises the cycle after acceptance and stays high until the response to the final word. A command offered while busy is ignored and starts no transfer.
- R3: Before bus_gnt has been seen, bus_rsp is ignored and the first address is held.
- R4: Address and mask advance only on a cycle with bus_rsp high after the grant; otherwise they hold.
- R5: cmd_len bit 10 set selects block mode: bits 9:6 give the width in words and bits 5:0 the height in rows. Words in a row are BYTES apart. The word after a row end is the previous row start plus cmd_stride times BYTES. The start address is rounded down to a word boundary.
- R6: A width or height field of zero is treated as one.
- R7: cmd_len bit 10 clear selects linear mode: bits 9:0 give a byte count (zero counts as one). Consecutive words are issued from the word that holds the start byte through the word that holds the last byte.
- R8: Mask bit i covers byte i of the word, with bit 0 at the lowest address. In linear mode the first word clears the bits below the start offset and the last word clears the bits above the end offset. In block mode every mask is all ones.
- R9: xfer_done is a one-cycle pulse in the cycle after the final response. In that cycle bus_req is low and cmd_ready is high.
- R10: bus_write holds the accepted direction for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Generator idle; command taken this cycle if valid |
| cmd_write | input | 1 | 1 = write transfer, 0 = read |
| cmd_addr | input | ADDR_W | Starting byte address |
| cmd_len | input | 11 | Length code (mode bit, width/height or byte count) |
| cmd_stride | input | STRIDE_W | Row stride in words (block mode) |
| bus_req | output | 1 | Bus request, held for the whole transfer |
| bus_gnt | input | 1 | Bus grant from the target |
| bus_write | output | 1 | Direction of the current transfer |
| bus_addr | output | ADDR_W | Word-aligned byte address of the current word |
| bus_mask | output | DATA_W/8 | Byte-valid mask of the current word |
| bus_rsp | input | 1 | Target accepted write word / read word valid |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the command fields are stable on the accepting cycle. They also assume that the start address plus the total extent of a block never wraps the address space, and that the target raises bus_rsp only for words the generator presents. The stimulus picks start addresses and strides far from the address top. It drives bus_rsp high before the grant only on purpose, to show that those cycles are ignored. Each grant is a single pulse after the request rises, and commands offered during a transfer are one-cycle pokes whose only observable effect would be a stray request after completion.

// File: rtl/bmag_pkg.sv
package bmag_pkg;

   localparam int LEN_W    = 11;
   localparam int BLK_BIT  = 10;
   localparam int SIZE_HI  = 9;
   localparam int WID_HI   = 9;
   localparam int WID_LO   = 6;
   localparam int HGT_HI   = 5;
   localparam int HGT_LO   = 0;
   localparam int ROW_W    = HGT_HI - HGT_LO + 1;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_XFER = 2'd2
   } gen_state_t;

endpackage

// File: rtl/bmag_cmd_decode.sv
module bmag_cmd_decode
   import bmag_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int BYTES  = 4,
   parameter int OFF_W  = 2,
   parameter int CNT_W  = 11
) (
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [LEN_W-1:0]   len_i,
   output logic [ADDR_W-1:0]  base_o,
   output logic [CNT_W-1:0]   row_len_o,
   output logic [ROW_W-1:0]   rows_o,
   output logic [OFF_W-1:0]   off_o,
   output logic [OFF_W-1:0]   end_off_o,
   output logic               is_block_o
);
   localparam int SH = $clog2(BYTES);
   localparam int EW = LEN_W + OFF_W;

   logic [EW-1:0]   size_c;
   logic [EW-1:0]   end_pos_c;
   logic [EW-1:0]   off_ext_c;
   logic [WID_HI-WID_LO:0] wid_c;
   logic [ROW_W-1:0]       hgt_c;

   always_comb begin
      is_block_o = len_i[BLK_BIT];
      wid_c      = len_i[WID_HI:WID_LO];
      hgt_c      = len_i[HGT_HI:HGT_LO];
      off_ext_c  = EW'(addr_i & ADDR_W'(BYTES-1));
      size_c     = (len_i[SIZE_HI:0] == '0) ? EW'(1) : EW'(len_i[SIZE_HI:0]);
      end_pos_c  = off_ext_c + size_c - EW'(1);
      base_o     = addr_i & ~ADDR_W'(BYTES-1);
      off_o      = OFF_W'(off_ext_c);
      end_off_o  = OFF_W'(end_pos_c & EW'(BYTES-1));
      if (is_block_o) begin
         row_len_o = (wid_c == '0) ? CNT_W'(1) : CNT_W'(wid_c);
         rows_o    = (hgt_c == '0) ? ROW_W'(1) : hgt_c;
      end else begin
         row_len_o = CNT_W'(end_pos_c >> SH) + CNT_W'(1);
         rows_o    = ROW_W'(1);
      end
   end

endmodule

// File: rtl/bmag_walker.sv
module bmag_walker
   import bmag_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int BYTES    = 4,
   parameter int CNT_W    = 11,
   parameter int STRIDE_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic                step_i,
   input  logic [ADDR_W-1:0]   base_i,
   input  logic [CNT_W-1:0]    row_len_i,
   input  logic [ROW_W-1:0]    rows_i,
   input  logic [STRIDE_W-1:0] stride_i,
   output logic [ADDR_W-1:0]   addr_o,
   output logic                first_o,
   output logic                last_o
);
   localparam int SH = $clog2(BYTES);

   logic [ADDR_W-1:0]   row_base_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [CNT_W-1:0]    col_q;
   logic [CNT_W-1:0]    row_len_q;
   logic [ROW_W-1:0]    row_q;
   logic [ROW_W-1:0]    rows_q;
   logic [STRIDE_W-1:0] stride_q;
   logic [ADDR_W-1:0]   stride_bytes;
   logic                row_end;
   logic                last_row;

   always_comb begin
      stride_bytes = ADDR_W'(stride_q) << SH;
      row_end      = (col_q == row_len_q - CNT_W'(1));
      last_row     = (row_q == rows_q - ROW_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_base_q <= '0;
         addr_q     <= '0;
         col_q      <= '0;
         row_q      <= '0;
         row_len_q  <= CNT_W'(1);
         rows_q     <= ROW_W'(1);
         stride_q   <= '0;
      end else if (load_i) begin
         row_base_q <= base_i;
         addr_q     <= base_i;
         col_q      <= '0;
         row_q      <= '0;
         row_len_q  <= row_len_i;
         rows_q     <= rows_i;
         stride_q   <= stride_i;
      end else if (step_i && !(row_end && last_row)) begin
         if (row_end) begin
            col_q      <= '0;
            row_q      <= row_q + ROW_W'(1);
            row_base_q <= row_base_q + stride_bytes;
            addr_q     <= row_base_q + stride_bytes;
         end else begin
            col_q  <= col_q + CNT_W'(1);
            addr_q <= addr_q + ADDR_W'(BYTES);
         end
      end
   end

   assign addr_o  = addr_q;
   assign first_o = (col_q == '0) && (row_q == '0);
   assign last_o  = row_end && last_row;

   assert_col_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !row_end) |=> (addr_q == $past(addr_q) + ADDR_W'(BYTES)));

   assert_row_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && row_end && !last_row) |=> (addr_q == $past(row_base_q) + $past(stride_bytes)));

   assert_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (row_len_q != '0) && (rows_q != '0));

endmodule

// File: rtl/bmag_mask_gen.sv
module bmag_mask_gen #(
   parameter int BYTES = 4,
   parameter int OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [OFF_W-1:0] off_i,
   input  logic [OFF_W-1:0] end_off_i,
   input  logic             block_i,
   input  logic             first_i,
   input  logic             last_i,
   input  logic             active_i,
   output logic [BYTES-1:0] mask_o
);
   logic [OFF_W-1:0] off_q;
   logic [OFF_W-1:0] end_q;
   logic             blk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         off_q <= '0;
         end_q <= '1;
         blk_q <= 1'b1;
      end else if (load_i) begin
         off_q <= off_i;
         end_q <= end_off_i;
         blk_q <= block_i;
      end
   end

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      logic above_start;
      logic below_end;
      always_comb begin
         above_start = !first_i || (OFF_W'(i) >= off_q);
         below_end   = !last_i  || (OFF_W'(i) <= end_q);
         mask_o[i]   = blk_q || (above_start && below_end);
      end
   end

   assert_mask_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      active_i |-> (mask_o != '0));

endmodule

// File: rtl/blk_xfer_agen.sv
module blk_xfer_agen
   import bmag_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int STRIDE_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   output logic                 cmd_ready,
   input  logic                 cmd_write,
   input  logic [ADDR_W-1:0]    cmd_addr,
   input  logic [LEN_W-1:0]     cmd_len,
   input  logic [STRIDE_W-1:0]  cmd_stride,
   output logic                 bus_req,
   input  logic                 bus_gnt,
   output logic                 bus_write,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [DATA_W/8-1:0]  bus_mask,
   input  logic                 bus_rsp,
   output logic                 xfer_done
);
   localparam int BYTES = DATA_W / 8;
   localparam int OFF_W = (BYTES > 1) ? $clog2(BYTES) : 1;
   localparam int CNT_W = LEN_W;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be a nonzero multiple of 8");
   end
   if ((BYTES & (BYTES - 1)) != 0) begin : g_bad_bytes
      $error("DATA_W/8 must be a power of two");
   end
   if (STRIDE_W > ADDR_W || ADDR_W <= OFF_W) begin : g_bad_addr_w
      $error("ADDR_W must exceed the byte offset and cover the stride");
   end

   gen_state_t state_q, state_d;
   logic       write_q;
   logic       done_q;
   logic       accept;
   logic       step;
   logic       last_beat;
   logic       first_beat;

   logic [ADDR_W-1:0] dec_base;
   logic [CNT_W-1:0]  dec_row_len;
   logic [ROW_W-1:0]  dec_rows;
   logic [OFF_W-1:0]  dec_off;
   logic [OFF_W-1:0]  dec_end_off;
   logic              dec_block;

   always_comb begin
      accept  = cmd_valid && (state_q == ST_IDLE);
      step    = (state_q == ST_XFER) && bus_rsp;
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (accept)               state_d = ST_REQ;
         ST_REQ:  if (bus_gnt)              state_d = ST_XFER;
         ST_XFER: if (bus_rsp && last_beat) state_d = ST_IDLE;
         default:                           state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         write_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= step && last_beat;
         if (accept) write_q <= cmd_write;
      end
   end

   bmag_cmd_decode #(
      .ADDR_W (ADDR_W),
      .BYTES  (BYTES),
      .OFF_W  (OFF_W),
      .CNT_W  (CNT_W)
   ) u_decode (
      .addr_i     (cmd_addr),
      .len_i      (cmd_len),
      .base_o     (dec_base),
      .row_len_o  (dec_row_len),
      .rows_o     (dec_rows),
      .off_o      (dec_off),
      .end_off_o  (dec_end_off),
      .is_block_o (dec_block)
   );

   bmag_walker #(
      .ADDR_W   (ADDR_W),
      .BYTES    (BYTES),
      .CNT_W    (CNT_W),
      .STRIDE_W (STRIDE_W)
   ) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept),
      .step_i    (step),
      .base_i    (dec_base),
      .row_len_i (dec_row_len),
      .rows_i    (dec_rows),
      .stride_i  (cmd_stride),
      .addr_o    (bus_addr),
      .first_o   (first_beat),
      .last_o    (last_beat)
   );

   bmag_mask_gen #(
      .BYTES (BYTES),
      .OFF_W (OFF_W)
   ) u_mask (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept),
      .off_i     (dec_off),
      .end_off_i (dec_end_off),
      .block_i   (dec_block),
      .first_i   (first_beat),
      .last_i    (last_beat),
      .active_i  (bus_req),
      .mask_o    (bus_mask)
   );

   assign cmd_ready = (state_q == ST_IDLE);
   assign bus_req   = (state_q != ST_IDLE);
   assign bus_write = write_q;
   assign xfer_done = done_q;

   assert_req_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> bus_req);

   assert_hold_no_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_rsp) |=> ($stable(bus_addr) && $stable(bus_mask)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (!bus_req && cmd_ready));

   assert_dir_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && $past(bus_req)) |-> $stable(bus_write));

endmodule

// File: tb/tb_blk_xfer_agen.sv
`timescale 1ns/1ps
module tb_blk_xfer_agen;

   typedef struct packed {
      logic        wr;
      logic        gap;
      logic [31:0] addr;
      logic [10:0] len;
      logic [15:0] stride;
      logic [11:0] words;
      logic [3:0]  lmask;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t TAB [NV] = '{
      '{1'b1, 1'b0, 32'h0000_0100, 11'h008, 16'd0,     12'd2,   4'hF}, // R7 aligned 8 bytes
      '{1'b1, 1'b1, 32'h0000_0203, 11'h006, 16'd0,     12'd3,   4'h1}, // R8 partial ends
      '{1'b1, 1'b0, 32'h0000_0301, 11'h002, 16'd0,     12'd1,   4'h6}, // R8 single word
      '{1'b0, 1'b0, 32'h0000_0402, 11'h000, 16'd0,     12'd1,   4'h4}, // R7 zero count
      '{1'b0, 1'b1, 32'h0000_1000, 11'h4C2, 16'd16,    12'd6,   4'hF}, // R5 3x2 block
      '{1'b1, 1'b0, 32'h0000_2006, 11'h400, 16'd5,     12'd1,   4'hF}, // R6 zero fields
      '{1'b1, 1'b1, 32'h0000_3000, 11'h443, 16'h0100,  12'd3,   4'hF}, // R5 column walk
      '{1'b1, 1'b0, 32'h0000_0010, 11'h3FF, 16'd0,     12'd256, 4'h7}, // R7 max count
      '{1'b0, 1'b0, 32'h0000_0500, 11'h482, 16'd0,     12'd4,   4'hF}  // R5 zero stride
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic        cmd_write = 1'b0;
   logic [31:0] cmd_addr = '0;
   logic [10:0] cmd_len = '0;
   logic [15:0] cmd_stride = '0;
   logic        bus_req;
   logic        bus_gnt = 1'b0;
   logic        bus_write;
   logic [31:0] bus_addr;
   logic [3:0]  bus_mask;
   logic        bus_rsp = 1'b0;
   logic        xfer_done;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   blk_xfer_agen #(.ADDR_W(32), .DATA_W(32), .STRIDE_W(16)) dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_stride(cmd_stride),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_mask(bus_mask), .bus_rsp(bus_rsp),
      .xfer_done(xfer_done)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_addr(input vec_t v, input int k);
      logic [31:0] base;
      int w, r, c;
      base = v.addr & ~32'h3;
      if (v.len[10]) begin
         w = (v.len[9:6] == 0) ? 1 : int'(v.len[9:6]);
         r = k / w;
         c = k % w;
         return base + 32'(r) * 32'(v.stride) * 32'd4 + 32'(c) * 32'd4;
      end
      return base + 32'(k) * 32'd4;
   endfunction

   function automatic logic [3:0] exp_mask(input vec_t v, input int k);
      int off, sz, e, n;
      logic [3:0] m;
      if (v.len[10]) return 4'hF;
      off = int'(v.addr[1:0]);
      sz  = (v.len[9:0] == 0) ? 1 : int'(v.len[9:0]);
      e   = off + sz - 1;
      n   = e / 4 + 1;
      m   = 4'hF;
      if (k == 0)     m = m & 4'(4'hF << off);
      if (k == n - 1) m = m & 4'(4'hF >> (3 - e % 4));
      return m;
   endfunction

   task automatic start_cmd(input vec_t v);
      @(negedge clk);
      check(cmd_ready == 1'b1, "R2 ready when idle", 64'(cmd_ready), 64'd1);
      cmd_valid  = 1'b1;
      cmd_write  = v.wr;
      cmd_addr   = v.addr;
      cmd_len    = v.len;
      cmd_stride = v.stride;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(bus_req == 1'b1, "R2 request after accept", 64'(bus_req), 64'd1);
      check(bus_write == v.wr, "R10 direction", 64'(bus_write), 64'(v.wr));
      // R3: responses before grant must not move the walk
      bus_rsp = 1'b1;
      repeat (2) @(negedge clk);
      check(bus_addr == exp_addr(v, 0), "R3 held before grant", 64'(bus_addr), 64'(exp_addr(v, 0)));
      bus_rsp = 1'b0;
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
   endtask

   task automatic run_cmd(input vec_t v, input bit poke);
      int nw;
      nw = int'(v.words);
      start_cmd(v);
      for (int k = 0; k < nw; k++) begin
         if (v.gap && (k % 2 == 1)) begin
            bus_rsp = 1'b0;
            @(negedge clk);
            check(bus_addr == exp_addr(v, k), "R4 hold without response", 64'(bus_addr), 64'(exp_addr(v, k)));
         end
         check(bus_req == 1'b1, "R2 request held", 64'(bus_req), 64'd1);
         check(bus_addr == exp_addr(v, k), v.len[10] ? "R5 block address" : "R7 linear address",
               64'(bus_addr), 64'(exp_addr(v, k)));
         check(bus_mask == exp_mask(v, k), "R8 mask", 64'(bus_mask), 64'(exp_mask(v, k)));
         check(bus_write == v.wr, "R10 direction held", 64'(bus_write), 64'(v.wr));
         if (k == nw - 1)
            check(bus_mask == v.lmask, "R8 last mask", 64'(bus_mask), 64'(v.lmask));
         if (poke && k == 1) begin
            cmd_valid = 1'b1;
            cmd_addr  = 32'h000D_EAD0;
            cmd_len   = 11'h005;
         end
         bus_rsp = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
         bus_rsp   = 1'b0;
      end
      check(xfer_done == 1'b1, "R9 done pulse", 64'(xfer_done), 64'd1);
      check(bus_req == 1'b0, "R9 request dropped", 64'(bus_req), 64'd0);
      check(cmd_ready == 1'b1, "R9 ready again", 64'(cmd_ready), 64'd1);
      @(negedge clk);
      check(xfer_done == 1'b0, "R9 single-cycle done", 64'(xfer_done), 64'd0);
      check(bus_req == 1'b0, "R2 busy command ignored", 64'(bus_req), 64'd0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: state while reset is held
      check(bus_req == 1'b0, "R1 req in reset", 64'(bus_req), 64'd0);
      check(xfer_done == 1'b0, "R1 done in reset", 64'(xfer_done), 64'd0);
      check(cmd_ready == 1'b1, "R1 ready in reset", 64'(cmd_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check(bus_req == 1'b0, "R1 req after reset", 64'(bus_req), 64'd0);

      for (int i = 0; i < NV; i++) run_cmd(TAB[i], 1'b0);

      // R2: command offered mid-transfer is ignored
      run_cmd(TAB[4], 1'b1);

      // R1: reset in the middle of a long transfer
      start_cmd(TAB[7]);
      for (int k = 0; k < 3; k++) begin
         bus_rsp = 1'b1;
         @(negedge clk);
      end
      bus_rsp = 1'b0;
      check(bus_addr == exp_addr(TAB[7], 3), "R7 partial walk", 64'(bus_addr), 64'(exp_addr(TAB[7], 3)));
      rst_n = 1'b0;
      #1;
      check(bus_req == 1'b0, "R1 req cleared by reset", 64'(bus_req), 64'd0);
      check(cmd_ready == 1'b1, "R1 ready after abort", 64'(cmd_ready), 64'd1);
      check(xfer_done == 1'b0, "R1 no done on abort", 64'(xfer_done), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      run_cmd(TAB[1], 1'b0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule